// File: doc/BRIEF.md
# GPIO Controller with Change Interrupts and Modem-Pin Muxing

This block gives eight general-purpose pins a small register interface: a direction register, a state register, a per-pin interrupt enable register and a control register. Pad inputs pass through a two-flop synchroniser. Every enabled input pin is compared against a reference level, and a difference raises a pending interrupt. The OR of all pending interrupts drives one interrupt line. A read of the state register clears the pending interrupts.

A control bit selects one of two input modes. In transparent mode a pin that returns to its reference level withdraws its interrupt by itself. In latch mode the first change freezes the new level into that pin's state bit, and the interrupt stays pending until the state register is read, even if the pin reverts. Two further control bits hand each four-pin group over to a channel's modem-control signals. A self-clearing control bit issues a one-cycle soft reset that returns every register to zero.

The register bus is a plain strobe interface with a combinational read mux. Reads have no wait states.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are selected by `addr_i`: 0 direction (1 = output), 1 state, 2 interrupt enable, 3 control. After reset every register reads 0. Control bits 7:4 always read 0.
- R2: `pin_oe_o` equals the direction register. A general-purpose pin's `pin_o` bit equals the written state bit. A read of the state register returns the synchronised pad level of each pin that is not latched, two clock edges after the pad changes.
- R3: An input pin (direction 0) whose enable bit is 1 raises `irq_o` when its synchronised level differs from its reference. A pin whose enable bit is 0 never raises `irq_o`.
- R4: With control bit 0 = 0 (transparent mode), a pending pin interrupt withdraws when the pin returns to its reference level. A state-register read makes the current level the new reference, which clears `irq_o` at the next edge.
- R5: With control bit 0 = 1 (latch mode), the first change on an enabled input captures the new level into that pin's state bit and keeps the interrupt pending after the pin reverts. The captured level is what a state read returns, and that read clears the interrupt and the capture.
- R6: Control bit 1 assigns pins 7:4 to modem channel 1, and control bit 2 assigns pins 3:0 to channel 0. Within a group, bit 3 is ring indicate, bit 2 carrier detect, bit 1 DTR and bit 0 DSR. In modem mode, the DTR pin's `pin_o` follows `dtr_n_i[ch]`, and its output enable still comes from the direction register. `ri_n_o`, `cd_n_o` and `dsr_n_o` carry the synchronised pins, and read 1 for a group not in modem mode.
- R7: Interrupt enable bits of a group in modem mode have no effect: changes on those pins do not raise `irq_o`.
- R8: Writing 1 to control bit 3 pulses `soft_rst_o` for exactly one cycle and clears the direction, state, enable and control registers. Control bit 3 reads 0.
- R9: Pins configured as outputs never raise an interrupt, even when enabled and toggled through the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a state read clears interrupts) |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables |
| dtr_n_i | input | 2 | DTR from each modem channel |
| ri_n_o | output | 2 | Ring indicate to each modem channel |
| cd_n_o | output | 2 | Carrier detect to each modem channel |
| dsr_n_o | output | 2 | DSR to each modem channel |
| irq_o | output | 1 | OR of pending pin interrupts |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
A lost or stale reference level shows on `irq_o` within three cycles of a pad change. It shows either as an interrupt that never rises or as one that refuses to withdraw when the pin reverts in transparent mode. A capture flag that drops early shows as `irq_o` falling after a revert in latch mode, and as the wrong level in the next state read. A wrong modem mask or a register left set after a soft reset shows one cycle later, on `irq_o`, `pin_o`, `pin_oe_o` or the modem inputs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned GPIO_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [1:0] {
    REG_DIR   = 2'd0,
    REG_STATE = 2'd1,
    REG_IEN   = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_LATCH = 0;
  localparam int unsigned CTRL_SRST  = 3;

  // modem signal positions inside a four-pin group
  localparam int unsigned NIB_DSR = 0;
  localparam int unsigned NIB_DTR = 1;
  localparam int unsigned NIB_CD  = 2;
  localparam int unsigned NIB_RI  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_i,
  input  logic armed_i,
  input  logic latch_mode_i,
  input  logic clr_i,
  input  logic sync_i,
  output logic pend_o,
  output logic rd_val_o
);
  logic ref_q, latched_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q     <= 1'b0;
      latched_q <= 1'b0;
      hold_q    <= 1'b0;
    end else if (soft_i) begin
      ref_q     <= 1'b0;
      latched_q <= 1'b0;
      hold_q    <= 1'b0;
    end else if (clr_i || !armed_i || !latch_mode_i) begin
      // track, or re-arm from the current level
      if (clr_i || !armed_i) ref_q <= sync_i;
      latched_q <= 1'b0;
    end else if (!latched_q && (sync_i != ref_q)) begin
      latched_q <= 1'b1;
      hold_q    <= sync_i;
    end
  end

  assign pend_o   = armed_i & (latch_mode_i ? latched_q : (sync_i != ref_q));
  assign rd_val_o = latched_q ? hold_q : sync_i;

  // R5: a capture survives a reverting pin until read
  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_q && latch_mode_i && armed_i && !clr_i && !soft_i
      |=> latched_q && $stable(hold_q));

  // R5: a state read drops the capture
  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latched_q);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned N_CH = PINS / NIB_W
) (
  input  logic [PINS-1:0] state_i,
  input  logic [PINS-1:0] sync_i,
  input  logic [N_CH-1:0] modem_sel_i,
  input  logic [N_CH-1:0] dtr_n_i,
  output logic [PINS-1:0] pin_o,
  output logic [PINS-1:0] modem_pin_o,
  output logic [N_CH-1:0] ri_n_o,
  output logic [N_CH-1:0] cd_n_o,
  output logic [N_CH-1:0] dsr_n_o
);
  import gpio_irq_pkg::*;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned B = c * NIB_W;
    for (genvar b = 0; b < NIB_W; b++) begin : g_bit
      if (b == NIB_DTR) begin : g_dtr
        assign pin_o[B+b] = modem_sel_i[c] ? dtr_n_i[c] : state_i[B+b];
      end else begin : g_gp
        assign pin_o[B+b] = state_i[B+b];
      end
      assign modem_pin_o[B+b] = modem_sel_i[c];
    end
    assign ri_n_o[c]  = modem_sel_i[c] ? sync_i[B+NIB_RI]  : 1'b1;
    assign cd_n_o[c]  = modem_sel_i[c] ? sync_i[B+NIB_CD]  : 1'b1;
    assign dsr_n_o[c] = modem_sel_i[c] ? sync_i[B+NIB_DSR] : 1'b1;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned PINS  = gpio_irq_pkg::GPIO_W,
  parameter int unsigned NIB_W = gpio_irq_pkg::NIB_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [1:0]              addr_i,
  input  logic [PINS-1:0]         wdata_i,
  output logic [PINS-1:0]         rdata_o,
  input  logic [PINS-1:0]         pin_i,
  output logic [PINS-1:0]         pin_o,
  output logic [PINS-1:0]         pin_oe_o,
  input  logic [PINS/NIB_W-1:0]   dtr_n_i,
  output logic [PINS/NIB_W-1:0]   ri_n_o,
  output logic [PINS/NIB_W-1:0]   cd_n_o,
  output logic [PINS/NIB_W-1:0]   dsr_n_o,
  output logic                    irq_o,
  output logic                    soft_rst_o
);
  import gpio_irq_pkg::*;

  localparam int unsigned N_CH   = PINS / NIB_W;
  localparam int unsigned CTRL_W = N_CH + 1;

  logic [PINS-1:0]   dir_q, state_q, ien_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              srst_q;
  logic              srst_req, clr;
  logic [PINS-1:0]   sync, modem_pin, armed, pend, rd_val;
  logic [N_CH-1:0]   modem_sel;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(addr_i);
  assign srst_req = wr_en_i && (sel == REG_CTRL) && wdata_i[CTRL_SRST];
  assign clr      = rd_en_i && (sel == REG_STATE) && !srst_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      state_q <= '0;
      ien_q   <= '0;
      ctrl_q  <= '0;
      srst_q  <= 1'b0;
    end else if (srst_req) begin
      dir_q   <= '0;
      state_q <= '0;
      ien_q   <= '0;
      ctrl_q  <= '0;
      srst_q  <= 1'b1;
    end else begin
      srst_q <= 1'b0;
      if (wr_en_i) begin
        unique case (sel)
          REG_DIR:   dir_q   <= wdata_i;
          REG_STATE: state_q <= wdata_i;
          REG_IEN:   ien_q   <= wdata_i;
          REG_CTRL:  ctrl_q  <= wdata_i[CTRL_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // group c is selected by control bit N_CH-c (upper group by bit 1)
  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    assign modem_sel[c] = ctrl_q[N_CH-c];
  end

  gpio_sync #(.W(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync)
  );

  gpio_pin_mux #(.PINS(PINS), .NIB_W(NIB_W)) u_mux (
    .state_i     (state_q),
    .sync_i      (sync),
    .modem_sel_i (modem_sel),
    .dtr_n_i     (dtr_n_i),
    .pin_o       (pin_o),
    .modem_pin_o (modem_pin),
    .ri_n_o      (ri_n_o),
    .cd_n_o      (cd_n_o),
    .dsr_n_o     (dsr_n_o)
  );

  assign armed = ien_q & ~dir_q & ~modem_pin;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_pin_irq u_pin (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .soft_i       (srst_req),
      .armed_i      (armed[i]),
      .latch_mode_i (ctrl_q[CTRL_LATCH]),
      .clr_i        (clr),
      .sync_i       (sync[i]),
      .pend_o       (pend[i]),
      .rd_val_o     (rd_val[i])
    );
  end

  always_comb begin
    unique case (sel)
      REG_DIR:   rdata_o = dir_q;
      REG_STATE: rdata_o = rd_val;
      REG_IEN:   rdata_o = ien_q;
      REG_CTRL:  rdata_o = PINS'(ctrl_q);
      default:   rdata_o = '0;
    endcase
  end

  assign pin_oe_o   = dir_q;
  assign irq_o      = |pend;
  assign soft_rst_o = srst_q;

  // R3 R7 R9: no armed pin means no interrupt
  p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ien_q & ~dir_q & ~modem_pin) == '0) |-> !irq_o);

  // R8: reset request produces a pulse one cycle later
  p_srst_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_req |=> soft_rst_o);

  // R8: the pulse is a single cycle
  p_srst_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o || $past(srst_req));

  // R8: registers are cleared while the pulse is high
  p_srst_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (dir_q == '0) && (ien_q == '0) && (ctrl_q == '0) && (state_q == '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] ext = '0, pin_in, pin_out, pin_oe;
  logic [1:0] dtr_n = 2'b11, ri_n, cd_n, dsr_n;
  logic       irq, soft_rst;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  // pad model: driven pins loop back
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .dtr_n_i(dtr_n), .ri_n_o(ri_n), .cd_n_o(cd_n), .dsr_n_o(dsr_n),
    .irq_o(irq), .soft_rst_o(soft_rst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] dir, input logic [7:0] ien, input logic [7:0] ctrl);
    logic [7:0] d;
    ext = '0;
    wr(2'd3, ctrl);
    wr(2'd0, dir);
    wr(2'd1, 8'h00);
    wr(2'd2, ien);
    settle();
    rd(2'd1, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset register", d, 8'h00);
    end
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R6 idle modem inputs", {2'b0, ri_n, cd_n, dsr_n}, 8'h3F);
  endtask

  task automatic t_output();
    logic [7:0] d;
    setup(8'h0F, 8'h00, 8'h00);
    wr(2'd1, 8'hA5);
    chk("R2 output enable", pin_oe, 8'h0F);
    chk("R2 pin level", pin_out, 8'hA5);
    ext = 8'h30;
    settle();
    rd(2'd1, d);
    chk("R2 state read", d, 8'h35);
    wr(2'd3, 8'hF0);
    rd(2'd3, d);
    chk("R1 reserved control bits", d, 8'h00);
  endtask

  task automatic t_transparent();
    logic [7:0] d;
    setup(8'h00, 8'h01, 8'h00);
    ext = 8'h02; settle();
    chk("R3 disabled pin", {7'b0, irq}, 8'h00);
    ext = 8'h03; settle();
    chk("R3 enabled change", {7'b0, irq}, 8'h01);
    ext = 8'h02; settle();
    chk("R4 revert withdraws", {7'b0, irq}, 8'h00);
    ext = 8'h03; settle();
    chk("R4 pending again", {7'b0, irq}, 8'h01);
    rd(2'd1, d);
    chk("R4 state read", d, 8'h03);
    chk("R4 read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    setup(8'h00, 8'h10, 8'h01);
    ext = 8'h10; settle();
    chk("R5 capture irq", {7'b0, irq}, 8'h01);
    ext = 8'h00; settle();
    chk("R5 held after revert", {7'b0, irq}, 8'h01);
    rd(2'd1, d);
    chk("R5 captured level", d, 8'h10);
    chk("R5 read clears", {7'b0, irq}, 8'h00);
    rd(2'd1, d);
    chk("R5 live level after clear", d, 8'h00);
  endtask

  task automatic t_out_no_irq();
    setup(8'hFF, 8'hFF, 8'h00);
    wr(2'd1, 8'hFF);
    settle();
    chk("R9 output toggle", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_modem();
    setup(8'h22, 8'h00, 8'h06);
    dtr_n = 2'b01;
    ext = 8'h49;
    settle();
    chk("R6 dtr drive", pin_out & 8'h22, 8'h02);
    chk("R6 dtr enable", pin_oe, 8'h22);
    chk("R6 modem inputs", {2'b0, ri_n, cd_n, dsr_n}, {2'b0, 2'b01, 2'b10, 2'b01});
    wr(2'd2, 8'hFF);
    ext = 8'hB6; settle();
    chk("R7 modem pins masked", {7'b0, irq}, 8'h00);
    chk("R6 carrier detect", {6'b0, cd_n}, 8'h01);
    wr(2'd3, 8'h04);
    @(negedge clk);
    chk("R6 released group idle", {6'b0, cd_n}, 8'h03);
    chk("R7 no irq on release", {7'b0, irq}, 8'h00);
    ext = 8'h36; settle();
    chk("R7 enable effective again", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    setup(8'hFF, 8'h0F, 8'h07);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h08);
    chk("R8 pulse high", {7'b0, soft_rst}, 8'h01);
    @(negedge clk);
    chk("R8 pulse single", {7'b0, soft_rst}, 8'h00);
    chk("R8 outputs cleared", pin_oe | pin_out, 8'h00);
    rd(2'd0, d); chk("R8 direction cleared", d, 8'h00);
    rd(2'd2, d); chk("R8 enable cleared", d, 8'h00);
    rd(2'd3, d); chk("R8 control cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_transparent();
    t_latch();
    t_out_no_irq();
    t_modem();
    t_soft_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule